// File: doc/BRIEF.md
# CCD Readout Region Classifier

This block follows one output tap of an interline CCD and works out where each streamed sample sits on the sensor. A column counter advances on every qualified sample. A row counter advances on each line marker. A frame marker returns the row counter to zero. From this position every sample gets one of four region tags: dummy, dark, buffer or active. The sizes of every region are parameters, and the defaults describe one half of a full-resolution line.

On each line that is not a dummy or dark row, the block adds up the shielded dark samples and divides the sum into a dark reference. It skips the outermost column at each edge of the shielded strip, because light can leak into those columns. The reference is ready before the first active column of the same line. Active samples leave the block with this reference subtracted, and the result is clamped at zero. All other samples pass through unchanged, so downstream logic can still use them for its own statistics.

The output is a valid/data stream with sideband signals: a region tag, a start-of-line flag and an end-of-frame flag. There is no ready signal, because the sensor cannot be paused. The downstream consumer must accept one sample on every cycle in which out_valid is high.

Top module: `ccd_region_tagger`

## Requirements
- R1: After reset, out_valid stays low until the first qualified input sample.
- R2: Each sample with pix_valid high produces exactly one output sample on the next clock edge. A cycle without pix_valid produces no output.
- R3: Along a line, the column tag follows this fixed order: DUMMY_COLS columns tagged 3 (dummy), then DARK_COLS columns tagged 2 (dark), then BUF_COLS+GAP_COLS columns tagged 1 (buffer), then ACT_COLS columns tagged 0 (active).
- R4: Down a frame, the row tag follows this fixed order: dummy (3), dark (2), buffer (1), active (0), then buffer (1), dark (2), dummy (3), using the row-count parameters. A sample's out_region is the larger of its row tag and its column tag.
- R5: For each line whose row tag is 0 or 1, the dark reference equals the floor of the sum of that line's dark-strip samples, excluding the first and last dark column, divided by DARK_COLS-2.
- R6: An active sample (tag 0) is output as pixel minus that line's dark reference. If the pixel is below the reference, the output is 0.
- R7: A sample with a nonzero tag is output with its input value unchanged.
- R8: out_sol is high exactly on the output of a sample that arrived with line_start. out_eof is high exactly on the sample at the last column of the last row.
- R9: Cycles without pix_valid do not move the position counters. Gaps of any length inside a line leave the tags unchanged.
- R10: A sample that arrives with frame_start is placed at row 0, column 0, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input sample qualifier |
| line_start | input | 1 | Marks the first sample of a line |
| frame_start | input | 1 | Marks the first sample of a frame (set together with line_start) |
| pix_data | input | DATA_W | Digitised sample |
| out_valid | output | 1 | Output sample qualifier; the consumer cannot stall it |
| out_data | output | DATA_W | Dark-corrected active sample, or the raw value for other regions |
| out_region | output | 2 | Tag: 0 active, 1 buffer, 2 dark, 3 dummy |
| out_sol | output | 1 | Start-of-line flag |
| out_eof | output | 1 | End-of-frame flag |

## Verification
The bench drives a reduced geometry with five trusted dark columns, so the divider uses its constant-multiply variant. The edge dark columns and the dummy columns carry very large values. If the reference picks up a wrong column, the corrected active data changes visibly. The active data contains one value below the reference and one at full scale, to show the clamp at zero and the upper limit. One frame is sent with idle gaps inside its lines, which separates real position tracking from simple cycle counting. One frame is cut short by a new frame marker, which shows that the counters resynchronise on frame_start rather than relying on a full row count.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;
  typedef enum logic [1:0] {
    REG_ACTIVE = 2'd0,
    REG_BUFFER = 2'd1,
    REG_DARK   = 2'd2,
    REG_DUMMY  = 2'd3
  } region_e;
endpackage

// File: rtl/ccd_pos_counter.sv
module ccd_pos_counter #(
  parameter int LINE_LEN   = 1701,
  parameter int FRAME_ROWS = 2522,
  localparam int CW = $clog2(LINE_LEN),
  localparam int RW = $clog2(FRAME_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          line_start,
  input  logic          frame_start,
  output logic [CW-1:0] pos_col,
  output logic [RW-1:0] pos_row
);
  localparam logic [CW-1:0] LAST_COL = CW'(LINE_LEN - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(FRAME_ROWS - 1);

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;

  always_comb begin
    pos_col = line_start ? '0 : col_q;
    if (frame_start)                          pos_row = '0;
    else if (line_start && row_q != LAST_ROW) pos_row = row_q + 1'b1;
    else                                      pos_row = row_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (smp_valid) begin
      col_q <= (pos_col == LAST_COL) ? pos_col : pos_col + 1'b1;
      row_q <= pos_row;
    end
  end

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(col_q) && $stable(row_q)); // R9
  AST_FRAME_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && frame_start |=> row_q == '0 && col_q == CW'(1)); // R10
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL); // R3
endmodule

// File: rtl/ccd_region_map.sv
module ccd_region_map
  import ccd_tag_pkg::*;
#(
  parameter int DUMMY_COLS = 11,
  parameter int DARK_COLS  = 22,
  parameter int BUF_COLS   = 12,
  parameter int GAP_COLS   = 8,
  parameter int ACT_COLS   = 1648,
  parameter int DUMMY_ROWS = 1,
  parameter int DARK_ROWS  = 12,
  parameter int BUF_ROWS   = 12,
  parameter int ACT_ROWS   = 2472,
  localparam int LINE_LEN   = DUMMY_COLS + DARK_COLS + BUF_COLS + GAP_COLS + ACT_COLS,
  localparam int FRAME_ROWS = 2 * (DUMMY_ROWS + DARK_ROWS + BUF_ROWS) + ACT_ROWS,
  localparam int CW = $clog2(LINE_LEN),
  localparam int RW = $clog2(FRAME_ROWS)
) (
  input  logic [CW-1:0] pos_col,
  input  logic [RW-1:0] pos_row,
  output region_e       region,
  output logic          trusted,
  output logic          trusted_first,
  output logic          trusted_last,
  output logic          frame_last
);
  // column boundaries (exclusive upper ends)
  localparam int C_DUM = DUMMY_COLS;
  localparam int C_DRK = C_DUM + DARK_COLS;
  localparam int C_BUF = C_DRK + BUF_COLS + GAP_COLS;
  // row boundaries (exclusive upper ends)
  localparam int R_DUM0 = DUMMY_ROWS;
  localparam int R_DRK0 = R_DUM0 + DARK_ROWS;
  localparam int R_BUF0 = R_DRK0 + BUF_ROWS;
  localparam int R_ACT  = R_BUF0 + ACT_ROWS;
  localparam int R_BUF1 = R_ACT + BUF_ROWS;
  localparam int R_DRK1 = R_BUF1 + DARK_ROWS;

  region_e col_tag, row_tag;
  int unsigned c, r;

  always_comb begin
    c = 32'(pos_col);
    r = 32'(pos_row);
    if (c < C_DUM)      col_tag = REG_DUMMY;
    else if (c < C_DRK) col_tag = REG_DARK;
    else if (c < C_BUF) col_tag = REG_BUFFER;
    else                col_tag = REG_ACTIVE;

    if (r < R_DUM0)      row_tag = REG_DUMMY;
    else if (r < R_DRK0) row_tag = REG_DARK;
    else if (r < R_BUF0) row_tag = REG_BUFFER;
    else if (r < R_ACT)  row_tag = REG_ACTIVE;
    else if (r < R_BUF1) row_tag = REG_BUFFER;
    else if (r < R_DRK1) row_tag = REG_DARK;
    else                 row_tag = REG_DUMMY;

    region        = (row_tag > col_tag) ? row_tag : col_tag;
    trusted       = (row_tag <= REG_BUFFER) && (c >= C_DUM + 1) && (c <= C_DRK - 2);
    trusted_first = trusted && (c == C_DUM + 1);
    trusted_last  = trusted && (c == C_DRK - 2);
    frame_last    = (c == LINE_LEN - 1) && (r == FRAME_ROWS - 1);
  end
endmodule

// File: rtl/ccd_dark_ref.sv
module ccd_dark_ref #(
  parameter int DATA_W      = 12,
  parameter int TRUST_N     = 20,
  parameter int RECIP_SHIFT = 20,
  localparam int SW = DATA_W + $clog2(TRUST_N + 1),
  localparam int PW = SW + RECIP_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              trusted,
  input  logic              trusted_first,
  input  logic              trusted_last,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] dark_ref
);
  logic [SW-1:0]     sum_q, sum_next;
  logic [DATA_W-1:0] quot;

  assign sum_next = (trusted_first ? '0 : sum_q) + SW'(smp_data);

  generate
    if ((TRUST_N & (TRUST_N - 1)) == 0) begin : g_shift
      assign quot = DATA_W'(sum_next >> $clog2(TRUST_N));
    end else begin : g_recip
      localparam int unsigned RECIP = ((32'd1 << RECIP_SHIFT) + TRUST_N - 1) / TRUST_N;
      logic [PW-1:0] prod;
      assign prod = PW'(sum_next) * PW'(RECIP);
      assign quot = DATA_W'(prod >> RECIP_SHIFT);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q    <= '0;
      dark_ref <= '0;
    end else if (smp_valid && trusted) begin
      sum_q <= sum_next;
      if (trusted_last) dark_ref <= quot;
    end
  end

  AST_REF_LATCH_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && trusted_last) |=> $stable(dark_ref)); // R5
endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
  import ccd_tag_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int DUMMY_COLS  = 11,
  parameter int DARK_COLS   = 22,
  parameter int BUF_COLS    = 12,
  parameter int GAP_COLS    = 8,
  parameter int ACT_COLS    = 1648,
  parameter int DUMMY_ROWS  = 1,
  parameter int DARK_ROWS   = 12,
  parameter int BUF_ROWS    = 12,
  parameter int ACT_ROWS    = 2472,
  parameter int RECIP_SHIFT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic [DATA_W-1:0] pix_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_region,
  output logic              out_sol,
  output logic              out_eof
);
  localparam int LINE_LEN   = DUMMY_COLS + DARK_COLS + BUF_COLS + GAP_COLS + ACT_COLS;
  localparam int FRAME_ROWS = 2 * (DUMMY_ROWS + DARK_ROWS + BUF_ROWS) + ACT_ROWS;
  localparam int CW = $clog2(LINE_LEN);
  localparam int RW = $clog2(FRAME_ROWS);
  localparam int TRUST_N = DARK_COLS - 2;

  logic [CW-1:0]     pos_col;
  logic [RW-1:0]     pos_row;
  region_e           region;
  logic              trusted, trusted_first, trusted_last, frame_last;
  logic [DATA_W-1:0] dark_ref;
  logic [DATA_W-1:0] corrected;

  ccd_pos_counter #(.LINE_LEN(LINE_LEN), .FRAME_ROWS(FRAME_ROWS)) u_pos (
    .clk(clk), .rst_n(rst_n), .smp_valid(pix_valid),
    .line_start(line_start), .frame_start(frame_start),
    .pos_col(pos_col), .pos_row(pos_row)
  );

  ccd_region_map #(
    .DUMMY_COLS(DUMMY_COLS), .DARK_COLS(DARK_COLS), .BUF_COLS(BUF_COLS),
    .GAP_COLS(GAP_COLS), .ACT_COLS(ACT_COLS), .DUMMY_ROWS(DUMMY_ROWS),
    .DARK_ROWS(DARK_ROWS), .BUF_ROWS(BUF_ROWS), .ACT_ROWS(ACT_ROWS)
  ) u_map (
    .pos_col(pos_col), .pos_row(pos_row), .region(region),
    .trusted(trusted), .trusted_first(trusted_first),
    .trusted_last(trusted_last), .frame_last(frame_last)
  );

  ccd_dark_ref #(.DATA_W(DATA_W), .TRUST_N(TRUST_N), .RECIP_SHIFT(RECIP_SHIFT)) u_ref (
    .clk(clk), .rst_n(rst_n), .smp_valid(pix_valid), .trusted(trusted),
    .trusted_first(trusted_first), .trusted_last(trusted_last),
    .smp_data(pix_data), .dark_ref(dark_ref)
  );

  assign corrected = (pix_data >= dark_ref) ? pix_data - dark_ref : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_region <= '0;
      out_sol    <= 1'b0;
      out_eof    <= 1'b0;
    end else begin
      out_valid <= pix_valid;
      out_sol   <= pix_valid && line_start;
      out_eof   <= pix_valid && frame_last;
      if (pix_valid) begin
        out_region <= region;
        out_data   <= (region == REG_ACTIVE) ? corrected : pix_data;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid); // R2
  AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_eof) |-> out_valid); // R8
  AST_ACTIVE_NOT_ABOVE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && region == REG_ACTIVE |=> out_data <= $past(pix_data)); // R6
endmodule

// File: tb/ccd_region_tagger_tb_top.sv
module ccd_region_tagger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int DC = 2, KC = 7, BC = 2, GC = 1, AC = 5;
  localparam int DR = 1, KR = 2, BR = 1, AR = 3;
  localparam int LEN  = DC + KC + BC + GC + AC;
  localparam int ROWS = 2 * (DR + KR + BR) + AR;

  typedef struct packed {
    logic [1:0]    region;
    logic [DW-1:0] data;
    logic          sol;
    logic          eof;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic out_valid, out_sol, out_eof;
  logic [DW-1:0] out_data;
  logic [1:0] out_region;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_region_tagger #(
    .DATA_W(DW), .DUMMY_COLS(DC), .DARK_COLS(KC), .BUF_COLS(BC), .GAP_COLS(GC),
    .ACT_COLS(AC), .DUMMY_ROWS(DR), .DARK_ROWS(KR), .BUF_ROWS(BR), .ACT_ROWS(AR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
    .frame_start(frame_start), .pix_data(pix_data), .out_valid(out_valid),
    .out_data(out_data), .out_region(out_region), .out_sol(out_sol), .out_eof(out_eof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int ctag(int c);
    if (c < DC) return 3;
    if (c < DC + KC) return 2;
    if (c < DC + KC + BC + GC) return 1;
    return 0;
  endfunction

  function automatic int rtag(int r);
    if (r < DR) return 3;
    if (r < DR + KR) return 2;
    if (r < DR + KR + BR) return 1;
    if (r < DR + KR + BR + AR) return 0;
    if (r < DR + KR + 2*BR + AR) return 1;
    if (r < DR + 2*KR + 2*BR + AR) return 2;
    return 3;
  endfunction

  function automatic int gen(int f, int r, int c);
    if (c < DC) return 3000 + c;
    if (c == DC || c == DC + KC - 1) return 4000;
    if (c < DC + KC) return 100 + ((r*13 + c*7 + f*5) % 60);
    if (c == DC + KC + BC + GC) return 5;
    if (c == LEN - 1) return 4095;
    return (r*37 + c*101 + f*59) % 4096;
  endfunction

  task automatic frame(input int f, input int nrows, input bit gaps);
    for (int r = 0; r < nrows; r++) begin
      int sum = 0, refv, tg, g, ev;
      exp_t e;
      for (int c = DC + 1; c <= DC + KC - 2; c++) sum += gen(f, r, c);
      refv = sum / (KC - 2);
      for (int c = 0; c < LEN; c++) begin
        if (gaps && ((r + c) % 3 == 0)) begin
          @(negedge clk);
          pix_valid = 1'b0; line_start = 1'b0; frame_start = 1'b0;
          pix_data = 12'hABC;
        end
        g  = gen(f, r, c);
        tg = (rtag(r) > ctag(c)) ? rtag(r) : ctag(c);
        ev = (tg == 0) ? ((g >= refv) ? g - refv : 0) : g;
        e.region = 2'(tg);
        e.data   = DW'(ev);
        e.sol    = (c == 0);
        e.eof    = (r == ROWS - 1) && (c == LEN - 1);
        @(negedge clk);
        pix_valid   = 1'b1;
        line_start  = (c == 0);
        frame_start = (c == 0) && (r == 0);
        pix_data    = DW'(g);
        exp_q.push_back(e);
      end
    end
    @(negedge clk);
    pix_valid = 1'b0; line_start = 1'b0; frame_start = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected output", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_region == e.region, "R3/R4 region", int'(out_region), int'(e.region));
        if (e.region == 2'd0)
          chk(out_data == e.data, "R5/R6 corrected data", int'(out_data), int'(e.data));
        else
          chk(out_data == e.data, "R7 raw data", int'(out_data), int'(e.data));
        chk(out_sol == e.sol, "R8 sol", int'(out_sol), int'(e.sol));
        chk(out_eof == e.eof, "R8 eof", int'(out_eof), int'(e.eof));
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
    end
    frame(0, ROWS, 1'b0);          // R3 R4 R5 R6 R7 R8 baseline
    frame(1, ROWS, 1'b1);          // R9 idle gaps inside lines
    frame(2, 5, 1'b0);             // R10 frame cut short
    frame(3, ROWS, 1'b0);          // R10 resynchronised frame
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 outputs outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule